// File: doc/BRIEF.md
# PLL Divisor Search Engine

This block picks PLL divider settings for a requested link clock. A caller presents a target frequency in kHz, selects one of two platform profiles and pulses a start strobe. The engine then walks every feedback multiplier M and post-divider P that the profile allows. For each pair it computes the output frequency (M × reference) / (P × N), keeps the pair whose output lies closest to the target, and packs the winner into a control word and a divider word. Those words are ready to be written into the PLL.

One candidate is evaluated per clock through a short pipeline. The scan stops early when a candidate hits the target exactly. A target outside the legal window does not start a scan. The engine reports an error and returns zeroed words instead. The multiplier is not written directly: it goes through a fixed non-linear seed table before it enters the divider word.

Top module: `pll_div_search`

## Requirements
- R1: A target below 300000 kHz or above 1150000 kHz makes `done_o` pulse with `range_err_o` = 1 and both `ctl_word_o` and `div_word_o` equal to zero. Exactly 300000 and exactly 1150000 are accepted.
- R2: With `prof_sel_i` = 0 the engine uses a 25000 kHz reference, N = 1, M from 62 to 92, and writes 0 into the log2(N) field.
- R3: With `prof_sel_i` = 1 the engine uses a 100000 kHz reference, N = 4, M from 70 to 96, and writes 2 into the log2(N) field.
- R4: Each candidate is (M × ref) / (P × N), truncated toward zero, with P from 2 to 6. The chosen pair has the smallest absolute difference from the target.
- R5: The scan order is M ascending in the outer loop and P ascending in the inner loop. On equal error the pair met first is kept.
- R6: A candidate with zero error ends the scan at once. For an exact hit on the first candidate, `done_o` rises no more than 8 clocks after the start strobe is sampled.
- R7: On success `ctl_word_o` (32 bits) has exactly one bit set, at position 20 + P − 2 (bits 24:20 form the post-divider field), and every other bit is zero.
- R8: On success `div_word_o` (32 bits) carries log2(N) in bits 18:16 and the M seed in bits 8:0. All other bits are zero.
- R9: The M seed comes from a 39-entry table indexed by M − 62, which covers M = 62 to 100.
- R10: `done_o` is high for one clock per accepted request. A start strobe that arrives while a search is running is ignored and does not change the result.
- R11: After reset `done_o` and `range_err_o` are 0 and both words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, sampled when idle |
| tgt_khz_i | input | 21 | Target link clock in kHz |
| prof_sel_i | input | 1 | Platform profile: 0 = 25 MHz reference, 1 = 100 MHz reference |
| done_o | output | 1 | One-clock completion pulse |
| range_err_o | output | 1 | Target was outside the legal window |
| ctl_word_o | output | 32 | Control word with one-hot post-divider field |
| div_word_o | output | 32 | Divider word with log2(N) and M seed |

## Verification
Some properties are checked on every cycle by the assertions. Each candidate that reaches the compare stage must have M and P inside the legal bounds. The best error held by the tracker must never grow during a scan. `done_o` must never last longer than one clock. A rejected target must come back with both words zero, and an accepted one with a control word whose single set bit lies inside the post-divider field. Other behaviours only show up in the bench's scenarios against an independent search model: which pair actually wins, how ties are broken, the seed values, the exact-hit early exit measured as latency, and whether a start strobe during a busy scan is ignored.

// File: rtl/pll_div_pkg.sv
// Shared constants, profile type and profile lookup for the PLL divisor search.
// Assumes frequencies in kHz and at most two platform profiles.
package pll_div_pkg;
    localparam int TGT_W     = 21;
    localparam int M_W       = 7;
    localparam int P_W       = 3;
    localparam int REF_W     = 17;
    localparam int PROD_W    = M_W + REF_W;
    localparam int DIVS_W    = 5;
    localparam int NLOG_W    = 3;
    localparam int SEED_W    = 9;
    localparam int WORD_W    = 32;
    localparam int P_MIN     = 2;
    localparam int P_MAX     = 6;
    localparam int P_SPAN    = P_MAX - P_MIN + 1;
    localparam int SEED_M0   = 62;
    localparam int SEED_N    = 39;
    localparam int CTL_P_LSB = 20;
    localparam int DIV_N_LSB = 16;
    localparam int DIV_M_LSB = 0;
    localparam logic [TGT_W-1:0] TGT_LO = TGT_W'(300000);
    localparam logic [TGT_W-1:0] TGT_HI = TGT_W'(1150000);

    typedef struct packed {
        logic [REF_W-1:0]  ref_khz;
        logic [M_W-1:0]    m_lo;
        logic [M_W-1:0]    m_hi;
        logic [DIVS_W-1:0] n_div;
        logic [NLOG_W-1:0] n_log2;
    } prof_t;

    function automatic prof_t prof_lookup(input logic sel);
        prof_t p;
        if (sel) begin
            p.ref_khz = REF_W'(100000);
            p.m_lo    = M_W'(70);
            p.m_hi    = M_W'(96);
            p.n_div   = DIVS_W'(4);
            p.n_log2  = NLOG_W'(2);
        end else begin
            p.ref_khz = REF_W'(25000);
            p.m_lo    = M_W'(62);
            p.m_hi    = M_W'(92);
            p.n_div   = DIVS_W'(1);
            p.n_log2  = NLOG_W'(0);
        end
        return p;
    endfunction
endpackage

// File: rtl/pll_cand_pipe.sv
// Candidate evaluator: stage A registers M*ref and P*N, stage B divides and
// forms the absolute error against the target. Assumes the reference, N and
// target stay stable for the whole scan.
module pll_cand_pipe
    import pll_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              in_vld_i,
    input  logic              in_last_i,
    input  logic [M_W-1:0]    in_m_i,
    input  logic [P_W-1:0]    in_p_i,
    input  logic [REF_W-1:0]  ref_khz_i,
    input  logic [DIVS_W-1:0] n_div_i,
    input  logic [TGT_W-1:0]  tgt_i,
    output logic              out_vld_o,
    output logic              out_last_o,
    output logic [M_W-1:0]    out_m_o,
    output logic [P_W-1:0]    out_p_o,
    output logic [PROD_W-1:0] out_err_o
);
    logic [PROD_W-1:0] a_prod;
    logic [DIVS_W-1:0] a_div;
    logic [PROD_W-1:0] quo;
    logic [PROD_W-1:0] tgt_ext;

    // Stage A: capture numerator and denominator of one candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_o  <= 1'b0;
            out_last_o <= 1'b0;
            out_m_o    <= '0;
            out_p_o    <= P_W'(P_MIN);
            a_prod     <= '0;
            a_div      <= DIVS_W'(1);
        end else begin
            out_vld_o  <= in_vld_i && !flush_i;
            out_last_o <= in_last_i;
            out_m_o    <= in_m_i;
            out_p_o    <= in_p_i;
            a_prod     <= PROD_W'(in_m_i) * PROD_W'(ref_khz_i);
            a_div      <= DIVS_W'(in_p_i) * n_div_i;
        end
    end

    // Stage B: truncating divide and absolute difference from the target.
    always_comb begin
        tgt_ext   = PROD_W'(tgt_i);
        quo       = a_prod / PROD_W'(a_div);
        out_err_o = (quo > tgt_ext) ? (quo - tgt_ext) : (tgt_ext - quo);
    end

    // R4: every evaluated candidate lies inside the legal M and P bounds.
    assert_cand_bounds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld_o |-> (out_p_o >= P_W'(P_MIN) && out_p_o <= P_W'(P_MAX)
                       && out_m_o >= M_W'(SEED_M0) && out_m_o < M_W'(SEED_M0 + SEED_N)));
endmodule

// File: rtl/pll_best_track.sv
// Keeps the best (M, P) seen so far. A candidate wins only with strictly
// smaller error. Assumes init_i is pulsed once before the first candidate.
module pll_best_track
    import pll_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              init_i,
    input  logic [TGT_W-1:0]  tgt_i,
    input  logic [M_W-1:0]    m_lo_i,
    input  logic              cand_vld_i,
    input  logic [M_W-1:0]    cand_m_i,
    input  logic [P_W-1:0]    cand_p_i,
    input  logic [PROD_W-1:0] cand_err_i,
    output logic              exact_o,
    output logic [M_W-1:0]    best_m_o,
    output logic [P_W-1:0]    best_p_o
);
    logic [PROD_W-1:0] best_err;

    // Seed the best error with the target, then replace on a strict improvement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_err <= '0;
            best_m_o <= M_W'(SEED_M0);
            best_p_o <= P_W'(P_MIN);
        end else if (init_i) begin
            best_err <= PROD_W'(tgt_i);
            best_m_o <= m_lo_i;
            best_p_o <= P_W'(P_MIN);
        end else if (cand_vld_i && cand_err_i < best_err) begin
            best_err <= cand_err_i;
            best_m_o <= cand_m_i;
            best_p_o <= cand_p_i;
        end
    end

    // Flag an exact hit so the sequencer can stop the scan.
    always_comb exact_o = cand_vld_i && (cand_err_i == '0);

    // R5: the held error never grows except on a new request.
    assert_best_monotonic_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i |=> best_err <= $past(best_err));
endmodule

// File: rtl/pll_word_enc.sv
// Packs the winning pair into control and divider words. M is mapped
// through a 39-entry seed table. Assumes the seed table covers M = 62..100.
module pll_word_enc
    import pll_div_pkg::*;
(
    input  logic [M_W-1:0]    m_i,
    input  logic [P_W-1:0]    p_i,
    input  logic [NLOG_W-1:0] n_log2_i,
    input  logic              rng_err_i,
    output logic [WORD_W-1:0] ctl_o,
    output logic [WORD_W-1:0] div_o
);
    logic [SEED_W-1:0] seed;

    // Seed lookup for M, one entry per value from 62 upward.
    always_comb begin
        case (m_i)
            7'd62: seed = 9'd426;  7'd63: seed = 9'd469;  7'd64: seed = 9'd234;
            7'd65: seed = 9'd373;  7'd66: seed = 9'd442;  7'd67: seed = 9'd221;
            7'd68: seed = 9'd110;  7'd69: seed = 9'd311;  7'd70: seed = 9'd411;
            7'd71: seed = 9'd461;  7'd72: seed = 9'd486;  7'd73: seed = 9'd243;
            7'd74: seed = 9'd377;  7'd75: seed = 9'd188;  7'd76: seed = 9'd350;
            7'd77: seed = 9'd175;  7'd78: seed = 9'd343;  7'd79: seed = 9'd427;
            7'd80: seed = 9'd213;  7'd81: seed = 9'd106;  7'd82: seed = 9'd53;
            7'd83: seed = 9'd282;  7'd84: seed = 9'd397;  7'd85: seed = 9'd454;
            7'd86: seed = 9'd227;  7'd87: seed = 9'd113;  7'd88: seed = 9'd56;
            7'd89: seed = 9'd284;  7'd90: seed = 9'd142;  7'd91: seed = 9'd71;
            7'd92: seed = 9'd35;   7'd93: seed = 9'd273;  7'd94: seed = 9'd136;
            7'd95: seed = 9'd324;  7'd96: seed = 9'd418;  7'd97: seed = 9'd465;
            7'd98: seed = 9'd488;  7'd99: seed = 9'd500;  7'd100: seed = 9'd506;
            default: seed = '0;
        endcase
    end

    // Build both words, or zeros when the request was rejected.
    always_comb begin
        if (rng_err_i) begin
            ctl_o = '0;
            div_o = '0;
        end else begin
            ctl_o = WORD_W'(1) << (CTL_P_LSB + 32'(p_i) - P_MIN);
            div_o = (WORD_W'(n_log2_i) << DIV_N_LSB) | (WORD_W'(seed) << DIV_M_LSB);
        end
    end
endmodule

// File: rtl/pll_div_search.sv
// Top of the PLL divisor search. The sequencer checks the target range,
// issues one (M, P) pair per clock, stops on an exact hit or after the last
// pair, and registers the encoded words with a one-clock done pulse.
// Assumes start_i is ignored while a search is running.
module pll_div_search
    import pll_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TGT_W-1:0]  tgt_khz_i,
    input  logic              prof_sel_i,
    output logic              done_o,
    output logic              range_err_o,
    output logic [WORD_W-1:0] ctl_word_o,
    output logic [WORD_W-1:0] div_word_o
);
    typedef enum logic [1:0] {ST_IDLE, ST_SCAN, ST_DRAIN, ST_FIN} st_t;

    st_t               st;
    logic [TGT_W-1:0]  tgt_q;
    logic              prof_sel_q;
    logic              rng_err_q;
    logic [M_W-1:0]    m_cnt;
    logic [P_W-1:0]    p_cnt;
    prof_t             prof_in;
    prof_t             prof_q;
    logic              in_rng;
    logic              init;
    logic              issue;
    logic              issue_last;
    logic              exact;
    logic              c_vld, c_last;
    logic [M_W-1:0]    c_m, best_m;
    logic [P_W-1:0]    c_p, best_p;
    logic [PROD_W-1:0] c_err;
    logic [WORD_W-1:0] ctl_enc, div_enc;

    // Decode profiles, the range window and the issue controls.
    always_comb begin
        prof_in    = prof_lookup(prof_sel_i);
        prof_q     = prof_lookup(prof_sel_q);
        in_rng     = (tgt_khz_i >= TGT_LO) && (tgt_khz_i <= TGT_HI);
        init       = (st == ST_IDLE) && start_i && in_rng;
        issue      = (st == ST_SCAN) && !exact;
        issue_last = (m_cnt == prof_q.m_hi) && (p_cnt == P_W'(P_MAX));
    end

    // Sequencer: accept, scan with P inner and M outer, drain, finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            tgt_q      <= '0;
            prof_sel_q <= 1'b0;
            rng_err_q  <= 1'b0;
            m_cnt      <= '0;
            p_cnt      <= P_W'(P_MIN);
        end else begin
            case (st)
                ST_IDLE: if (start_i) begin
                    tgt_q      <= tgt_khz_i;
                    prof_sel_q <= prof_sel_i;
                    rng_err_q  <= !in_rng;
                    m_cnt      <= prof_in.m_lo;
                    p_cnt      <= P_W'(P_MIN);
                    st         <= in_rng ? ST_SCAN : ST_FIN;
                end
                ST_SCAN: if (exact) begin
                    st <= ST_FIN;
                end else begin
                    if (issue_last) st <= ST_DRAIN;
                    if (p_cnt == P_W'(P_MAX)) begin
                        p_cnt <= P_W'(P_MIN);
                        m_cnt <= m_cnt + M_W'(1);
                    end else begin
                        p_cnt <= p_cnt + P_W'(1);
                    end
                end
                ST_DRAIN: if (exact || (c_vld && c_last)) st <= ST_FIN;
                default: st <= ST_IDLE;
            endcase
        end
    end

    pll_cand_pipe u_pipe (
        .clk(clk), .rst_n(rst_n), .flush_i(exact),
        .in_vld_i(issue), .in_last_i(issue_last),
        .in_m_i(m_cnt), .in_p_i(p_cnt),
        .ref_khz_i(prof_q.ref_khz), .n_div_i(prof_q.n_div), .tgt_i(tgt_q),
        .out_vld_o(c_vld), .out_last_o(c_last),
        .out_m_o(c_m), .out_p_o(c_p), .out_err_o(c_err)
    );

    pll_best_track u_best (
        .clk(clk), .rst_n(rst_n), .init_i(init),
        .tgt_i(tgt_khz_i), .m_lo_i(prof_in.m_lo),
        .cand_vld_i(c_vld), .cand_m_i(c_m), .cand_p_i(c_p), .cand_err_i(c_err),
        .exact_o(exact), .best_m_o(best_m), .best_p_o(best_p)
    );

    pll_word_enc u_enc (
        .m_i(best_m), .p_i(best_p), .n_log2_i(prof_q.n_log2),
        .rng_err_i(rng_err_q), .ctl_o(ctl_enc), .div_o(div_enc)
    );

    // Result registers: words and error held, done pulsed from the finish state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            range_err_o <= 1'b0;
            ctl_word_o  <= '0;
            div_word_o  <= '0;
        end else begin
            done_o <= (st == ST_FIN);
            if (st == ST_FIN) begin
                range_err_o <= rng_err_q;
                ctl_word_o  <= ctl_enc;
                div_word_o  <= div_enc;
            end
        end
    end

    // R10: completion is a single-cycle pulse.
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R1: a rejected target returns zeroed words.
    assert_reject_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && range_err_o) |-> (ctl_word_o == '0 && div_word_o == '0));
    // R7: an accepted result has one bit set, inside the post-divider field.
    assert_ctl_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !range_err_o) |-> ($onehot(ctl_word_o)
                                      && $onehot(ctl_word_o[CTL_P_LSB +: P_SPAN])));
endmodule

// File: tb/pll_div_search_bench.sv
`timescale 1ns/1ps
module pll_div_search_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [20:0] tgt_khz_i = '0;
    logic        prof_sel_i = 1'b0;
    logic        done_o, range_err_o;
    logic [31:0] ctl_word_o, div_word_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    localparam int SEEDS [0:38] = '{
        426, 469, 234, 373, 442, 221, 110, 311, 411, 461, 486, 243, 377,
        188, 350, 175, 343, 427, 213, 106, 53, 282, 397, 454, 227, 113,
        56, 284, 142, 71, 35, 273, 136, 324, 418, 465, 488, 500, 506};

    typedef struct {
        bit          err;
        logic [31:0] ctl;
        logic [31:0] dv;
        int          max_lat;
        int          start_cyc;
        string       tag;
    } item_t;

    item_t sb[$];

    pll_div_search u_pll_div_search (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .tgt_khz_i(tgt_khz_i),
        .prof_sel_i(prof_sel_i), .done_o(done_o), .range_err_o(range_err_o),
        .ctl_word_o(ctl_word_o), .div_word_o(div_word_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Independent search model built from R1..R9.
    function automatic void model(input int tgt, input bit prof,
                                  output bit e, output logic [31:0] c, output logic [31:0] d);
        int refk, n, nl, mlo, mhi, best, bm, bp, q, er;
        bit stop;
        refk = prof ? 100000 : 25000;
        n    = prof ? 4 : 1;
        nl   = prof ? 2 : 0;
        mlo  = prof ? 70 : 62;
        mhi  = prof ? 96 : 92;
        if (tgt < 300000 || tgt > 1150000) begin
            e = 1'b1; c = '0; d = '0;
            return;
        end
        best = tgt; bm = mlo; bp = 2; stop = 1'b0;
        for (int m = mlo; m <= mhi && !stop; m++) begin
            for (int p = 2; p <= 6 && !stop; p++) begin
                q  = (m * refk) / (p * n);
                er = (tgt > q) ? tgt - q : q - tgt;
                if (er < best) begin best = er; bm = m; bp = p; end
                if (er == 0) stop = 1'b1;
            end
        end
        e = 1'b0;
        c = 32'd1 << (20 + bp - 2);
        d = (32'(nl) << 16) | 32'(SEEDS[bm - 62]);
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: push the expected item, then pulse start.
    task automatic run_case(input int tgt, input bit prof, input int max_lat, input string tag);
        item_t it;
        model(tgt, prof, it.err, it.ctl, it.dv);
        it.max_lat = max_lat;
        it.tag = tag;
        @(negedge clk);
        it.start_cyc = cyc;
        sb.push_back(it);
        start_i = 1'b1; tgt_khz_i = 21'(tgt); prof_sel_i = prof;
        @(negedge clk);
        start_i = 1'b0;
        while (sb.size() != 0) @(negedge clk);
    endtask

    // Monitor: pop and compare on each completion.
    always @(negedge clk) begin
        if (rst_n && done_o) begin
            if (sb.size() == 0) begin
                check(1'b0, "R10 unexpected done", 32'd1, 32'd0);
            end else begin
                item_t it;
                it = sb.pop_front();
                check(range_err_o == it.err, {it.tag, " err"}, 32'(range_err_o), 32'(it.err));
                check(ctl_word_o == it.ctl, {it.tag, " R7 ctl"}, ctl_word_o, it.ctl);
                check(div_word_o == it.dv, {it.tag, " R8 R9 div"}, div_word_o, it.dv);
                if (it.max_lat > 0)
                    check((cyc - it.start_cyc) <= it.max_lat, {it.tag, " latency"},
                          32'(cyc - it.start_cyc), 32'(it.max_lat));
            end
        end
    end

    // Watchdog.
    initial begin
        while (cyc < 150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        check(done_o == 1'b0 && range_err_o == 1'b0, "R11 flags", {30'd0, done_o, range_err_o}, 32'd0);
        check(ctl_word_o == '0 && div_word_o == '0, "R11 words", ctl_word_o | div_word_o, 32'd0);

        run_case(299999,  1'b0, 0, "R1 below");
        run_case(1150001, 1'b1, 0, "R1 above");
        run_case(2000000, 1'b0, 0, "R1 far above");
        run_case(300000,  1'b0, 0, "R1 R2 low edge");
        run_case(1150000, 1'b1, 0, "R1 R3 high edge");
        run_case(775000,  1'b0, 8, "R6 R2 exact first");
        run_case(875000,  1'b1, 8, "R6 R3 exact first");
        run_case(781250,  1'b0, 0, "R5 tie");
        run_case(500000,  1'b0, 0, "R4 R2 mid");
        run_case(433333,  1'b0, 0, "R4 R2 odd");
        run_case(640000,  1'b1, 0, "R4 R3 mid");
        run_case(999999,  1'b1, 0, "R4 R3 high");
        run_case(1000000, 1'b0, 0, "R6 R2 exact mid");

        // R10: a second start during a running scan must be ignored
        begin
            item_t it;
            model(612345, 1'b0, it.err, it.ctl, it.dv);
            it.max_lat = 0; it.tag = "R10 busy start";
            @(negedge clk);
            it.start_cyc = cyc;
            sb.push_back(it);
            start_i = 1'b1; tgt_khz_i = 21'(612345); prof_sel_i = 1'b0;
            @(negedge clk);
            start_i = 1'b0;
            repeat (3) @(negedge clk);
            start_i = 1'b1; tgt_khz_i = 21'(875000); prof_sel_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            while (sb.size() != 0) @(negedge clk);
            repeat (10) @(negedge clk);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule